// File: doc/BRIEF.md
# Link Transmit Word Framer

This block forms the 32-bit word stream on the transmit side of a serial backplane link. It works ahead of serialization and line coding. In each word clock it takes a parallel data word, a 2-bit type tag and a transmit enable. From these it registers one outgoing word: an alignment word, an idle filler, a synchronization word, or a payload word scrambled by an additive LFSR keystream.

A synchronization word resets the scrambler to a fixed seed. The far end can then start descrambling at a known point. After reset, and whenever an initialization request is raised, the block sends only alignment words until the link reports that it is aligned. Until the first synchronization word after reset, a status output shows that the scrambler has not been seeded, and every payload word sent in that state is flagged. The alignment, idle and synchronization code values, the LFSR polynomial and the LFSR seed are all parameters.

Top module: `link_tx_framer`

## Requirements
- R1: While rst_ni is low, tx_word_o equals ALIGN_WORD, tx_kind_o is 2'b00, unseeded_o is 1 and data_err_o is 0.
- R2: From reset until a cycle in which aligned_i is high, every word sent is ALIGN_WORD with tx_kind_o = 2'b00. This holds regardless of tx_en_i, tx_type_i and tx_data_i.
- R3: A cycle with init_req_i high sends ALIGN_WORD. The block then keeps sending alignment words until aligned_i is high in a cycle without init_req_i.
- R4: Outside alignment, tx_en_i low sends IDLE_WORD with tx_kind_o = 2'b01.
- R5: Outside alignment, with tx_en_i high and tx_type_i = 2'b00, the block sends SYNC_WORD with tx_kind_o = 2'b10 and reloads the LFSR state with LFSR_SEED.
- R6: Outside alignment, with tx_en_i high and tx_type_i equal to 01, 10 or 11, the block sends tx_data_i XOR the current LFSR state, with tx_kind_o = 2'b11. The state then advances by 32 steps. Each step shifts left by one bit and inserts, at bit 0, the XOR of the state bits selected by LFSR_POLY.
- R7: Idle and alignment words leave the LFSR state unchanged, so the keystream continues across them.
- R8: Each output word is registered and reflects the inputs sampled at the preceding rising edge of clk_i.
- R9: unseeded_o is 1 from reset until the first synchronization word is sent. It falls in the same cycle that word appears on tx_word_o, and it stays 0 after that.
- R10: data_err_o is 1 exactly when the word on tx_word_o is a payload word that was sent while unseeded_o was still 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_req_i | input | 1 | Request to re-enter alignment |
| aligned_i | input | 1 | Link reports word alignment complete |
| tx_en_i | input | 1 | Input word valid; low sends idle |
| tx_type_i | input | 2 | Type tag: 00 sync, other values data |
| tx_data_i | input | 32 | Parallel payload word |
| tx_word_o | output | 32 | Registered outgoing word |
| tx_kind_o | output | 2 | Kind of outgoing word: 00 align, 01 idle, 10 sync, 11 data |
| unseeded_o | output | 1 | Scrambler not yet seeded by a sync word |
| data_err_o | output | 1 | Current payload word was sent unseeded |

## Verification
The bench uses the default parameters: a 32-bit word, distinct alignment, idle and sync codes, a dense feedback polynomial and an all-ones seed. With these values every kind of word is distinct at the port, and a stalled or wrongly advanced LFSR changes the next payload word. Directed sequences cover payload sent before the first sync, alignment re-entered in the middle of a stream, and long idle gaps. After that, random tags and enables are weighted so that syncs re-occur often enough to check reseeding at many points in the keystream.

// File: rtl/link_tx_pkg.sv
package link_tx_pkg;
  typedef enum logic [1:0] {
    KIND_ALIGN = 2'b00,
    KIND_IDLE  = 2'b01,
    KIND_SYNC  = 2'b10,
    KIND_DATA  = 2'b11
  } word_kind_e;

  localparam logic [1:0] TYPE_SYNC = 2'b00;
endpackage

// File: rtl/link_tx_lfsr.sv
module link_tx_lfsr #(
  parameter int unsigned       W     = 32,
  parameter int unsigned       STEPS = 32,
  parameter logic [W-1:0]      POLY  = 32'h8000_0057,
  parameter logic [W-1:0]      SEED  = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reseed_i,
  input  logic         adv_i,
  output logic [W-1:0] key_o
);
  logic [W-1:0] state_q, state_nx;

  // STEPS serial shifts folded into one word clock
  always_comb begin
    state_nx = state_q;
    for (int i = 0; i < STEPS; i++) begin
      state_nx = {state_nx[W-2:0], ^(state_nx & POLY)};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= SEED;
    else if (reseed_i) state_q <= SEED;
    else if (adv_i)    state_q <= state_nx;
  end

  assign key_o = state_q;

  // R5
  reseed_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reseed_i |=> key_o == SEED);
  // R7
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reseed_i && !adv_i) |=> $stable(key_o));
  always_comb begin
    assert (!(reseed_i && adv_i));
  end
endmodule

// File: rtl/link_tx_ctrl.sv
module link_tx_ctrl
  import link_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_req_i,
  input  logic       aligned_i,
  input  logic       tx_en_i,
  input  logic [1:0] tx_type_i,
  output word_kind_e kind_o,
  output logic       seeded_o
);
  logic align_q, in_align, seeded_q;

  assign in_align = init_req_i | (align_q & ~aligned_i);

  always_comb begin
    if (in_align)                    kind_o = KIND_ALIGN;
    else if (!tx_en_i)               kind_o = KIND_IDLE;
    else if (tx_type_i == TYPE_SYNC) kind_o = KIND_SYNC;
    else                             kind_o = KIND_DATA;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      align_q  <= 1'b1;
      seeded_q <= 1'b0;
    end else begin
      align_q <= in_align;
      if (kind_o == KIND_SYNC) seeded_q <= 1'b1;
    end
  end

  assign seeded_o = seeded_q;

  // R9
  seeded_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seeded_q |=> seeded_q);
  // R3
  init_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_req_i |-> kind_o == KIND_ALIGN);
endmodule

// File: rtl/link_tx_outreg.sv
module link_tx_outreg
  import link_tx_pkg::*;
#(
  parameter int unsigned  W          = 32,
  parameter logic [W-1:0] ALIGN_WORD = '0,
  parameter logic [W-1:0] IDLE_WORD  = '0,
  parameter logic [W-1:0] SYNC_WORD  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  word_kind_e   kind_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] key_i,
  input  logic         seeded_i,
  output logic [W-1:0] word_o,
  output logic [1:0]   kind_o,
  output logic         err_o
);
  logic [W-1:0] word_d;

  always_comb begin
    unique case (kind_i)
      KIND_ALIGN: word_d = ALIGN_WORD;
      KIND_IDLE:  word_d = IDLE_WORD;
      KIND_SYNC:  word_d = SYNC_WORD;
      default:    word_d = data_i ^ key_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= ALIGN_WORD;
      kind_o <= KIND_ALIGN;
      err_o  <= 1'b0;
    end else begin
      word_o <= word_d;
      kind_o <= kind_i;
      err_o  <= (kind_i == KIND_DATA) && !seeded_i;
    end
  end

  // R10
  err_on_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> kind_o == KIND_DATA);
  // R8
  kind_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> kind_o == $past(kind_i));
endmodule

// File: rtl/link_tx_framer.sv
module link_tx_framer
  import link_tx_pkg::*;
#(
  parameter int unsigned  W          = 32,
  parameter logic [W-1:0] ALIGN_WORD = 32'hF628_F628,
  parameter logic [W-1:0] IDLE_WORD  = 32'h0F0F_5A5A,
  parameter logic [W-1:0] SYNC_WORD  = 32'hC33C_A55A,
  parameter logic [W-1:0] LFSR_POLY  = 32'h8000_0057,
  parameter logic [W-1:0] LFSR_SEED  = 32'hFFFF_FFFF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_req_i,
  input  logic         aligned_i,
  input  logic         tx_en_i,
  input  logic [1:0]   tx_type_i,
  input  logic [W-1:0] tx_data_i,
  output logic [W-1:0] tx_word_o,
  output logic [1:0]   tx_kind_o,
  output logic         unseeded_o,
  output logic         data_err_o
);
  localparam int unsigned STEPS = W;

  word_kind_e   kind;
  logic         seeded;
  logic [W-1:0] key;

  link_tx_ctrl u_ctrl (
    .clk_i, .rst_ni, .init_req_i, .aligned_i, .tx_en_i, .tx_type_i,
    .kind_o(kind), .seeded_o(seeded)
  );

  link_tx_lfsr #(.W(W), .STEPS(STEPS), .POLY(LFSR_POLY), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i, .rst_ni,
    .reseed_i(kind == KIND_SYNC),
    .adv_i   (kind == KIND_DATA),
    .key_o   (key)
  );

  link_tx_outreg #(.W(W), .ALIGN_WORD(ALIGN_WORD), .IDLE_WORD(IDLE_WORD),
                   .SYNC_WORD(SYNC_WORD)) u_out (
    .clk_i, .rst_ni,
    .kind_i(kind), .data_i(tx_data_i), .key_i(key), .seeded_i(seeded),
    .word_o(tx_word_o), .kind_o(tx_kind_o), .err_o(data_err_o)
  );

  assign unseeded_o = !seeded;

  // R9
  sync_seeds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_kind_o == KIND_SYNC |-> !unseeded_o);
  // R4
  idle_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == KIND_IDLE) |=> tx_word_o == IDLE_WORD);
  // R3
  init_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_req_i |=> tx_kind_o == KIND_ALIGN && tx_word_o == ALIGN_WORD);
endmodule

// File: tb/sim_link_tx_framer.sv
module sim_link_tx_framer;
  localparam logic [31:0] AW = 32'hF628_F628;
  localparam logic [31:0] IW = 32'h0F0F_5A5A;
  localparam logic [31:0] SW = 32'hC33C_A55A;
  localparam logic [31:0] PL = 32'h8000_0057;
  localparam logic [31:0] SD = 32'hFFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic init_req = 0, aligned = 0, en = 0;
  logic [1:0] typ = 0;
  logic [31:0] din = 0;
  logic [31:0] word;
  logic [1:0] kind;
  logic unseeded, derr;

  always #2.5 clk = ~clk;

  link_tx_framer u0 (
    .clk_i(clk), .rst_ni(rst_n), .init_req_i(init_req), .aligned_i(aligned),
    .tx_en_i(en), .tx_type_i(typ), .tx_data_i(din),
    .tx_word_o(word), .tx_kind_o(kind), .unseeded_o(unseeded), .data_err_o(derr)
  );

  int checks = 0, fails = 0;
  logic m_align, m_seeded;
  logic [31:0] m_state;

  function automatic logic [31:0] adv32(input logic [31:0] s);
    for (int i = 0; i < 32; i++) s = {s[30:0], ^(s & PL)};
    return s;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // drive one cycle, predict, then sample at the following negedge
  task automatic step(input logic i_init, input logic i_al, input logic i_en,
                      input logic [1:0] i_typ, input logic [31:0] i_d, input string tag_ovr);
    logic ia;
    logic [1:0] ek;
    logic [31:0] ew;
    logic ee;
    string tg;
    init_req = i_init; aligned = i_al; en = i_en; typ = i_typ; din = i_d;
    ia = i_init | (m_align & ~i_al);
    if (ia)                ek = 2'b00;
    else if (!i_en)        ek = 2'b01;
    else if (i_typ == 0)   ek = 2'b10;
    else                   ek = 2'b11;
    ee = 1'b0;
    case (ek)
      2'b00: begin ew = AW; tg = "R2"; end
      2'b01: begin ew = IW; tg = "R4"; end
      2'b10: begin ew = SW; tg = "R5"; m_state = SD; m_seeded = 1'b1; end
      default: begin
        ew = i_d ^ m_state; tg = "R6"; ee = !m_seeded; m_state = adv32(m_state);
      end
    endcase
    m_align = ia;
    if (tag_ovr != "") tg = tag_ovr;
    @(posedge clk);
    @(negedge clk);
    chk(tg, "word", word, ew);
    chk(tg, "kind", {30'd0, kind}, {30'd0, ek});
    chk("R9", "unseeded", {31'd0, unseeded}, {31'd0, !m_seeded});
    chk("R10", "data_err", {31'd0, derr}, {31'd0, ee});
  endtask

  logic done = 1'b0;
  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_align = 1'b1; m_seeded = 1'b0; m_state = SD;
    #1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "word", word, AW);
    chk("R1", "kind", {30'd0, kind}, 32'd0);
    chk("R1", "unseeded", {31'd0, unseeded}, 32'd1);
    chk("R1", "data_err", {31'd0, derr}, 32'd0);
    rst_n = 1'b1;
    // R2: align held while not aligned, inputs ignored
    step(0, 0, 1, 2'b00, 32'h1111_1111, "R2");
    step(0, 0, 1, 2'b01, 32'h2222_2222, "R2");
    step(0, 0, 0, 2'b10, 32'h3333_3333, "R2");
    // leave alignment; payload before first sync flagged (R10)
    step(0, 1, 1, 2'b01, 32'hDEAD_BEEF, "R10");
    step(0, 0, 1, 2'b11, 32'h0000_0000, "R10");
    step(0, 0, 1, 2'b00, 32'h0, "R5");
    step(0, 0, 1, 2'b10, 32'hA5A5_A5A5, "R6");
    // R7: idles then data continues keystream
    for (int i = 0; i < 5; i++) step(0, 0, 0, 2'b01, 32'($urandom), "R7");
    step(0, 0, 1, 2'b11, 32'h1234_5678, "R7");
    // R3: init request mid-stream, hold until aligned
    step(1, 1, 1, 2'b01, 32'h5555_5555, "R3");
    step(0, 0, 1, 2'b01, 32'h6666_6666, "R3");
    step(0, 1, 1, 2'b01, 32'h7777_7777, "R7");
    // R8 latency: back-to-back distinct words
    step(0, 0, 1, 2'b00, 32'h0, "R8");
    step(0, 0, 1, 2'b01, 32'h0000_0001, "R8");
    step(0, 0, 0, 2'b01, 32'h0000_0002, "R8");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic r_init, r_al, r_en;
      logic [1:0] r_t;
      r_init = ($urandom % 64) == 0;
      r_al   = ($urandom % 4) != 0;
      r_en   = ($urandom % 5) != 0;
      r_t    = (($urandom % 8) == 0) ? 2'b00 : 2'(1 + ($urandom % 3));
      step(r_init, r_al, r_en, r_t, 32'($urandom), "");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule